// File: doc/BRIEF.md
# Interleaved multi-bank memory array

This block stores data in several independent synchronous RAM banks and presents them to a requester as one flat, byte-addressed space. A mode input chooses how addresses are spread over the banks. In interleaved mode, consecutive addresses rotate through the banks. In block mode, each bank owns one contiguous slice of the address space.

A requester issues a single request that covers one to four consecutive addresses, called lanes. The request carries a start address, a lane count, packed write data and a per-lane write enable. The block splits the request into per-bank accesses. Lanes that land in different banks are served in the same cycle. Lanes that collide on one bank are issued in successive cycles. Read results come back packed in lane order, with a one-cycle valid pulse. A request whose range runs past the top address is refused with an error pulse.

A parameter sets the bank count. The default is four banks of 256 bytes. A two-bank build stores even addresses in bank 0 and odd addresses in bank 1 when interleaved, so the pair behaves like one bank of twice the depth.

Top module: `imb_array`

## Requirements
- R1: In interleaved mode (mode_i = 0), lane address A is stored in bank A mod NUM_BANKS, at row A / NUM_BANKS. The bank index is therefore held in the low address bits.
- R2: In block mode (mode_i = 1), lane address A is stored in bank A / BANK_DEPTH, at row A mod BANK_DEPTH.
- R3: A request whose lanes all target distinct banks makes one bank access. If it is accepted at clock edge k, req_ready_o is low after edge k and high again after edge k+2.
- R4: A request whose lanes collide takes as many access cycles as the largest number of its lanes that share one bank. If it is accepted at edge k and needs n access cycles, req_ready_o stays low until edge k+n+1. Each bank serves at most one lane per cycle, and the lower lane goes first.
- R5: For a read, rsp_valid_o is high for exactly one cycle, in the cycle after the edge at which req_ready_o returns high. In that cycle, rsp_rdata_o bits [8i+7:8i] hold the byte at start address + i for each lane i below the lane count, and every other lane reads as zero. A write never raises rsp_valid_o.
- R6: A write stores lane i only when req_wen_i[i] is 1. A byte in a disabled lane keeps its old value.
- R7: A request is refused when any of these holds: its start address plus its lane count exceeds NUM_BANKS*BANK_DEPTH, its lane count is 0, or its lane count is above MAX_LANES. A refused request raises rsp_err_o for one cycle after the accepting edge, keeps req_ready_o high, writes no bank and raises no rsp_valid_o.
- R8: The mapping is taken from mode_i at the accepting edge only. Changes to mode_i while a request is in flight do not affect that request. Changing the mode does not move stored bytes.
- R9: While reset is asserted, and after it is released, req_ready_o is 1 and both rsp_valid_o and rsp_err_o are 0.
- R10: With NUM_BANKS = 2, interleaved mode stores even addresses in bank 0 and odd addresses in bank 1. A four-lane interleaved request then takes two access cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Mapping select: 0 interleaved, 1 block |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | ADDR_W (10) | Start address |
| req_lanes_i | input | CNT_W (3) | Number of consecutive lanes |
| req_wdata_i | input | MAX_LANES*DATA_W (32) | Write data, lane 0 in the low byte |
| req_wen_i | input | MAX_LANES (4) | Per-lane write enable |
| rsp_rdata_o | output | MAX_LANES*DATA_W (32) | Read data, lane 0 in the low byte |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_err_o | output | 1 | Refused-request pulse |

## Verification
A request accepted at edge k takes n access cycles. For that request, ready returns after edge k+n+1 and the read data and valid pulse appear in that same cycle. A refused request shows its error pulse right after edge k, with ready still high. The bench drives and samples on falling edges only. It counts the low-ready cycles that follow the accepting edge, compares that count with n+1 from its vector table, and reads the data and flags at the first falling edge where ready is high again. One falling edge later, it checks that the pulses have dropped. Expected bytes come from a model of each physical bank. The bench applies its own copy of both mappings to that model, so data written in one mode and read in the other shows whether stored bytes were relocated.

// File: rtl/imb_pkg.sv
package imb_pkg;
  typedef enum logic {
    MAP_ILV = 1'b0,
    MAP_BLK = 1'b1
  } map_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RESP = 2'd2
  } imb_state_e;
endpackage

// File: rtl/imb_addr_map.sv
module imb_addr_map #(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 256,
  parameter int MAX_LANES  = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = $clog2(BANK_DEPTH),
  localparam int ADDR_W = BANK_W + ROW_W
) (
  input  logic                                 mode_i,
  input  logic [ADDR_W-1:0]                    base_i,
  output logic [MAX_LANES-1:0][BANK_W-1:0]     bank_o,
  output logic [MAX_LANES-1:0][ROW_W-1:0]      row_o
);
  import imb_pkg::*;

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr = base_i + ADDR_W'(l);
    always_comb begin
      if (map_mode_e'(mode_i) == MAP_BLK) begin
        bank_o[l] = lane_addr[ADDR_W-1:ROW_W];
        row_o[l]  = lane_addr[ROW_W-1:0];
      end else begin
        bank_o[l] = lane_addr[BANK_W-1:0];
        row_o[l]  = lane_addr[ADDR_W-1:BANK_W];
      end
    end
  end
endmodule

// File: rtl/imb_bank_arb.sv
module imb_bank_arb #(
  parameter int NUM_BANKS = 4,
  parameter int MAX_LANES = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int LANE_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
  input  logic [MAX_LANES-1:0]              pend_i,
  input  logic [MAX_LANES-1:0][BANK_W-1:0]  lane_bank_i,
  output logic [NUM_BANKS-1:0]              bank_vld_o,
  output logic [NUM_BANKS-1:0][LANE_W-1:0]  bank_sel_o,
  output logic [MAX_LANES-1:0]              issue_o
);
  // lowest pending lane wins each bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      bank_vld_o[b] = 1'b0;
      bank_sel_o[b] = '0;
      for (int l = MAX_LANES - 1; l >= 0; l--) begin
        if (pend_i[l] && lane_bank_i[l] == BANK_W'(b)) begin
          bank_vld_o[b] = 1'b1;
          bank_sel_o[b] = LANE_W'(l);
        end
      end
    end
  end

  always_comb begin
    issue_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_vld_o[b]) issue_o[bank_sel_o[b]] = 1'b1;
  end

  // at most one issued lane per bank in any cycle
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    logic [MAX_LANES-1:0] hit;
    always_comb begin
      for (int l = 0; l < MAX_LANES; l++)
        hit[l] = issue_o[l] && lane_bank_i[l] == BANK_W'(b);
      assert_bank_onehot_R4: assert ($onehot0(hit));
    end
  end
endmodule

// File: rtl/imb_bank_ram.sv
module imb_bank_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem[row_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (en_i && !we_i) rdata_o <= mem[row_i];
  end
endmodule

// File: rtl/imb_array.sv
module imb_array #(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 256,
  parameter int DATA_W     = 8,
  parameter int MAX_LANES  = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = $clog2(BANK_DEPTH),
  localparam int ADDR_W = BANK_W + ROW_W,
  localparam int CNT_W  = $clog2(MAX_LANES + 1),
  localparam int LANE_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int BUS_W  = MAX_LANES * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_lanes_i,
  input  logic [BUS_W-1:0]  req_wdata_i,
  input  logic [MAX_LANES-1:0] req_wen_i,
  output logic [BUS_W-1:0]  rsp_rdata_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o
);
  import imb_pkg::*;

  localparam int TOTAL = NUM_BANKS * BANK_DEPTH;

  imb_state_e state_q;
  logic                                write_q;
  logic [MAX_LANES-1:0]                pend_q, issued_q, wen_q;
  logic [MAX_LANES-1:0][BANK_W-1:0]    lane_bank_q;
  logic [MAX_LANES-1:0][ROW_W-1:0]     lane_row_q;
  logic [MAX_LANES-1:0][DATA_W-1:0]    wdata_q, rdata_q;
  logic                                rvalid_q, err_q;

  logic [MAX_LANES-1:0][BANK_W-1:0]    map_bank;
  logic [MAX_LANES-1:0][ROW_W-1:0]     map_row;
  logic [MAX_LANES-1:0]                lane_mask, issue;
  logic [NUM_BANKS-1:0]                bank_vld, bank_en, bank_we;
  logic [NUM_BANKS-1:0][LANE_W-1:0]    bank_sel;
  logic [NUM_BANKS-1:0][ROW_W-1:0]     bank_row;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_wd, bank_rd;
  logic [ADDR_W:0]                     end_addr;
  logic                                req_bad, accept;

  imb_addr_map #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_DEPTH(BANK_DEPTH),
    .MAX_LANES (MAX_LANES)
  ) u_map (
    .mode_i(mode_i),
    .base_i(req_addr_i),
    .bank_o(map_bank),
    .row_o (map_row)
  );

  imb_bank_arb #(
    .NUM_BANKS(NUM_BANKS),
    .MAX_LANES(MAX_LANES)
  ) u_arb (
    .pend_i     (pend_q),
    .lane_bank_i(lane_bank_q),
    .bank_vld_o (bank_vld),
    .bank_sel_o (bank_sel),
    .issue_o    (issue)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b]  = (state_q == ST_RUN) && bank_vld[b];
    assign bank_we[b]  = bank_en[b] && write_q && wen_q[bank_sel[b]];
    assign bank_row[b] = lane_row_q[bank_sel[b]];
    assign bank_wd[b]  = wdata_q[bank_sel[b]];

    imb_bank_ram #(
      .DEPTH (BANK_DEPTH),
      .DATA_W(DATA_W)
    ) u_ram (
      .clk_i  (clk_i),
      .en_i   (bank_en[b]),
      .we_i   (bank_we[b]),
      .row_i  (bank_row[b]),
      .wdata_i(bank_wd[b]),
      .rdata_o(bank_rd[b])
    );
  end

  always_comb begin
    for (int l = 0; l < MAX_LANES; l++)
      lane_mask[l] = CNT_W'(l) < req_lanes_i;
  end

  assign end_addr = {1'b0, req_addr_i} + (ADDR_W+1)'(req_lanes_i);
  assign req_bad  = (req_lanes_i == '0) || (req_lanes_i > CNT_W'(MAX_LANES)) ||
                    (end_addr > (ADDR_W+1)'(TOTAL));
  assign accept   = (state_q == ST_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      write_q     <= 1'b0;
      pend_q      <= '0;
      issued_q    <= '0;
      wen_q       <= '0;
      lane_bank_q <= '0;
      lane_row_q  <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rvalid_q    <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept && req_bad) begin
            err_q <= 1'b1;
          end else if (accept) begin
            state_q     <= ST_RUN;
            write_q     <= req_write_i;
            pend_q      <= lane_mask;
            issued_q    <= '0;
            wen_q       <= req_wen_i;
            lane_bank_q <= map_bank;
            lane_row_q  <= map_row;
            wdata_q     <= req_wdata_i;
            rdata_q     <= '0;
          end
        end
        ST_RUN: begin
          pend_q   <= pend_q & ~issue;
          issued_q <= issue;
          if ((pend_q & ~issue) == '0) state_q <= ST_RESP;
        end
        ST_RESP: begin
          issued_q <= '0;
          rvalid_q <= !write_q;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      // bank output is one edge behind its access
      if (state_q != ST_IDLE && !write_q) begin
        for (int l = 0; l < MAX_LANES; l++)
          if (issued_q[l]) rdata_q[l] <= bank_rd[lane_bank_q[l]];
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_rdata_o = rdata_q;
  assign rsp_valid_o = rvalid_q;
  assign rsp_err_o   = err_q;

  assert_progress_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (issue != '0));
  assert_issue_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue & ~pend_q) == '0);
  assert_err_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (bank_we == '0));
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_valid_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);
  assert_map_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(lane_bank_q));
endmodule

// File: tb/sim_imb_array.sv
`timescale 1ns/1ps
module sim_imb_array;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0, req_valid_i = 1'b0, req_write_i = 1'b0;
  logic        req_ready_o, rsp_valid_o, rsp_err_o;
  logic [9:0]  req_addr_i = '0;
  logic [2:0]  req_lanes_i = '0;
  logic [31:0] req_wdata_i = '0, rsp_rdata_o;
  logic [3:0]  req_wen_i = '0;

  logic        b_mode = 1'b0, b_valid = 1'b0, b_write = 1'b0;
  logic        b_ready, b_rvalid, b_err;
  logic [8:0]  b_addr = '0;
  logic [2:0]  b_lanes = '0;
  logic [31:0] b_wdata = '0, b_rdata;
  logic [3:0]  b_wen = '0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem_m [4][256];

  always #2 clk_i = ~clk_i;

  imb_array u0 (
    .clk_i, .rst_ni, .mode_i, .req_valid_i, .req_ready_o, .req_write_i,
    .req_addr_i, .req_lanes_i, .req_wdata_i, .req_wen_i,
    .rsp_rdata_o, .rsp_valid_o, .rsp_err_o
  );

  imb_array #(.NUM_BANKS(2)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(b_mode), .req_valid_i(b_valid),
    .req_ready_o(b_ready), .req_write_i(b_write), .req_addr_i(b_addr),
    .req_lanes_i(b_lanes), .req_wdata_i(b_wdata), .req_wen_i(b_wen),
    .rsp_rdata_o(b_rdata), .rsp_valid_o(b_rvalid), .rsp_err_o(b_err)
  );

  typedef struct packed {
    logic        md;
    logic        wr;
    logic [9:0]  addr;
    logic [2:0]  lanes;
    logic [3:0]  wen;
    logic [31:0] wd;
    logic [2:0]  rounds;
    logic        err;
    logic        flip;
  } tv_t;

  localparam int NTV = 18;
  localparam tv_t TV [NTV] = '{
    '{1'b0, 1'b0, 10'd0,    3'd4, 4'h0, 32'h0,        3'd1, 1'b0, 1'b0}, // R1 R3
    '{1'b0, 1'b0, 10'd1021, 3'd3, 4'h0, 32'h0,        3'd1, 1'b0, 1'b0}, // top edge
    '{1'b0, 1'b1, 10'd8,    3'd4, 4'hA, 32'hA4A3A2A1, 3'd1, 1'b0, 1'b0}, // R6
    '{1'b0, 1'b0, 10'd8,    3'd4, 4'h0, 32'h0,        3'd1, 1'b0, 1'b0}, // R6 readback
    '{1'b1, 1'b0, 10'd0,    3'd4, 4'h0, 32'h0,        3'd4, 1'b0, 1'b0}, // R2 R4
    '{1'b1, 1'b0, 10'd254,  3'd4, 4'h0, 32'h0,        3'd2, 1'b0, 1'b0}, // R4 boundary
    '{1'b1, 1'b1, 10'd510,  3'd4, 4'hF, 32'hD4D3D2D1, 3'd2, 1'b0, 1'b0},
    '{1'b0, 1'b0, 10'd510,  3'd4, 4'h0, 32'h0,        3'd1, 1'b0, 1'b0}, // R8 no relocation
    '{1'b1, 1'b0, 10'd510,  3'd4, 4'h0, 32'h0,        3'd2, 1'b0, 1'b0},
    '{1'b1, 1'b0, 10'd768,  3'd1, 4'h0, 32'h0,        3'd1, 1'b0, 1'b0}, // R5 upper lanes zero
    '{1'b0, 1'b0, 10'd1022, 3'd3, 4'h0, 32'h0,        3'd0, 1'b1, 1'b0}, // R7 overrun
    '{1'b1, 1'b0, 10'd100,  3'd0, 4'h0, 32'h0,        3'd0, 1'b1, 1'b0}, // R7 zero lanes
    '{1'b0, 1'b0, 10'd0,    3'd5, 4'h0, 32'h0,        3'd0, 1'b1, 1'b0}, // R7 too many
    '{1'b0, 1'b1, 10'd1023, 3'd2, 4'hF, 32'hEEEEEEEE, 3'd0, 1'b1, 1'b0}, // R7 write refused
    '{1'b0, 1'b0, 10'd1023, 3'd1, 4'h0, 32'h0,        3'd1, 1'b0, 1'b0}, // R7 nothing written
    '{1'b1, 1'b0, 10'd2,    3'd2, 4'h0, 32'h0,        3'd2, 1'b0, 1'b0},
    '{1'b0, 1'b0, 10'd6,    3'd2, 4'h0, 32'h0,        3'd1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 10'd300,  3'd3, 4'h0, 32'h0,        3'd3, 1'b0, 1'b1}  // R8 flip while busy
  };

  function automatic int m_bank(logic md, int a);
    return md ? a / 256 : a % 4;
  endfunction
  function automatic int m_row(logic md, int a);
    return md ? a % 256 : a / 4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input tv_t t);
    logic [31:0] exp_d;
    int busy;
    exp_d = '0;
    if (!t.err && !t.wr)
      for (int l = 0; l < int'(t.lanes); l++)
        exp_d[8*l +: 8] = mem_m[m_bank(t.md, int'(t.addr) + l)][m_row(t.md, int'(t.addr) + l)];
    @(negedge clk_i);
    mode_i = t.md; req_write_i = t.wr; req_addr_i = t.addr; req_lanes_i = t.lanes;
    req_wen_i = t.wen; req_wdata_i = t.wd; req_valid_i = 1'b1;
    check(req_ready_o == 1'b1, "R3 ready before request", 32'(req_ready_o), 32'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (t.flip) mode_i = ~t.md;
    busy = 0;
    while (!req_ready_o && busy < 20) begin
      busy++;
      @(negedge clk_i);
    end
    if (t.err) begin
      check(busy == 0, "R7 ready stays high", 32'(busy), 32'd0);
      check(rsp_err_o == 1'b1, "R7 error pulse", 32'(rsp_err_o), 32'd1);
      check(rsp_valid_o == 1'b0, "R7 no valid", 32'(rsp_valid_o), 32'd0);
    end else begin
      check(busy == int'(t.rounds) + 1, t.rounds == 3'd1 ? "R3 busy cycles" : "R4 busy cycles",
            32'(busy), 32'(int'(t.rounds) + 1));
      check(rsp_err_o == 1'b0, "R7 no error", 32'(rsp_err_o), 32'd0);
      check(rsp_valid_o == !t.wr, "R5 valid pulse", 32'(rsp_valid_o), 32'(!t.wr));
      if (!t.wr)
        check(rsp_rdata_o == exp_d, t.md ? "R2 R5 R6 R8 read data" : "R1 R5 R6 R8 read data",
              rsp_rdata_o, exp_d);
    end
    if (!t.err && t.wr)
      for (int l = 0; l < int'(t.lanes); l++)
        if (t.wen[l])
          mem_m[m_bank(t.md, int'(t.addr) + l)][m_row(t.md, int'(t.addr) + l)] = t.wd[8*l +: 8];
    @(negedge clk_i);
    check(rsp_valid_o == 1'b0 && rsp_err_o == 1'b0, "R5 single pulse",
          {30'd0, rsp_valid_o, rsp_err_o}, 32'd0);
  endtask

  task automatic run_b(input logic md, input logic wr, input logic [8:0] a, input logic [2:0] ln,
                       input logic [31:0] wd, input logic [31:0] exp_d);
    int busy;
    @(negedge clk_i);
    b_mode = md; b_write = wr; b_addr = a; b_lanes = ln; b_wen = 4'hF; b_wdata = wd; b_valid = 1'b1;
    @(negedge clk_i);
    b_valid = 1'b0;
    busy = 0;
    while (!b_ready && busy < 20) begin
      busy++;
      @(negedge clk_i);
    end
    check(busy == 3, "R10 two access cycles", 32'(busy), 32'd3);
    if (!wr) check(b_rvalid && b_rdata == exp_d, "R10 two-bank data", b_rdata, exp_d);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    tv_t t;
    #1;
    // R9 reset state
    check(req_ready_o == 1'b1 && rsp_valid_o == 1'b0 && rsp_err_o == 1'b0, "R9 in reset",
          {29'd0, req_ready_o, rsp_valid_o, rsp_err_o}, 32'd4);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o == 1'b1 && rsp_valid_o == 1'b0 && rsp_err_o == 1'b0, "R9 after reset",
          {29'd0, req_ready_o, rsp_valid_o, rsp_err_o}, 32'd4);

    // preload every location, interleaved, one bank access per request
    for (int a = 0; a < 256; a++) begin
      t = '{1'b0, 1'b1, 10'(4*a), 3'd4, 4'hF, 32'h0, 3'd1, 1'b0, 1'b0};
      for (int l = 0; l < 4; l++) t.wd[8*l +: 8] = 8'((4*a + l) * 37 + 11);
      run_op(t);
    end

    for (int i = 0; i < NTV; i++) run_op(TV[i]);

    // R8: byte written in block mode, read at its interleaved alias
    t = '{1'b1, 1'b1, 10'd513, 3'd1, 4'h1, 32'h0000005A, 3'd1, 1'b0, 1'b0};
    run_op(t);
    t = '{1'b0, 1'b0, 10'd6, 3'd1, 4'h0, 32'h0, 3'd1, 1'b0, 1'b0};
    run_op(t);

    // R10 even/odd split on two banks
    run_b(1'b0, 1'b1, 9'd0, 3'd4, 32'h44332211, 32'h0);
    run_b(1'b1, 1'b0, 9'd0, 3'd2, 32'h0, 32'h00003311);
    run_b(1'b1, 1'b0, 9'd256, 3'd2, 32'h0, 32'h00004422);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule